// File: doc/BRIEF.md
# Byte-Stream Packet Device Register Block

The block is the host-facing register set of a simple packet device. A host on a 32-bit memory-mapped bus uses it in four ways. It reads a 64-bit probe identifier. It pulls received bytes one read at a time. It pushes transmit bytes one write at a time. It services a single interrupt line through a control word that holds two sticky causes and a software test bit.

Received frames arrive on a byte-stream input with a valid/ready handshake. Every byte of a frame carries the frame length, coded as length minus one. The block takes a new frame only when two things hold: no earlier frame still has unread bytes, and the host has acknowledged the previous receive cause. Until then the frame is held off and is not dropped. Bytes leave the source only when the host reads the receive data port. On transmit, the host first writes a byte count and then writes that many bytes. Each byte is sent on a byte-stream output, and the final byte is marked.

Top module: `pktreg_top`

## Requirements
- R1: The probe identifier reads as eight ASCII characters, "PKTNODE1" by default. Offset 0x00 returns characters 0..3 and offset 0x04 returns characters 4..7. Character 0 sits in bits 7:0, so character 0 is 'P' in the lowest byte and character 7 is '1' in the highest byte of 0x04.
- R2: Offset 0x08 reads 1 in bit 0 while the receive count or the transmit count is nonzero. Otherwise it reads 0. All other bits read 0.
- R3: A frame is accepted when three conditions hold: the receive count is 0, bit 1 of the interrupt control word (0x14) is clear, and rx_valid_i is high. On acceptance the receive count at 0x0C is loaded with rx_len_m1_i+1 and bit 1 is set. No byte is consumed on acceptance.
- R4: A read of offset 0x1C behaves in two ways. If the count is nonzero and rx_valid_i is high, it returns rx_data_i in bits 7:0 with zeros above, pulses rx_ready_o, and lowers the count by one. Otherwise it returns 0 and leaves the count unchanged.
- R5: While bit 1 of 0x14 is set, no new frame is accepted and rx_ready_o stays low, even when the count is 0 and a frame is offered.
- R6: A write to 0x10 while the transmit count is 0 loads the count, capped at 65536. While the count is nonzero, such writes are ignored.
- R7: A write to 0x20 while the transmit count is nonzero sends wdata_i[7:0] on tx_data_o with tx_valid_o high for the next cycle, and lowers the count by one. Higher write bits are ignored. The byte that brings the count to 0 has tx_last_o set. Writes to 0x20 while the count is 0 send nothing.
- R8: When the last transmit byte is written, the transmit count reads 0 and bit 0 of 0x14 is set.
- R9: Writing 1 to bit 0 or bit 1 of 0x14 clears that bit. Writing 0 to either bit leaves it unchanged.
- R10: A write to 0x14 with bit 31 set raises the test bit (bit 31). A write of all zeros clears it. Bits 30:2 always read 0.
- R11: irq_o is high exactly when bit 0, bit 1 or bit 31 of 0x14 is set.
- R12: Offset 0x18 returns the INFO_WORD parameter. Offset 0x20 and every other offset in the 0x40-byte window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| rx_valid_i | input | 1 | Receive byte present |
| rx_ready_o | output | 1 | Receive byte consumed this cycle |
| rx_data_i | input | 8 | Receive byte |
| rx_len_m1_i | input | 16 | Frame length minus one, held on every byte of the frame |
| tx_valid_o | output | 1 | Transmit byte present |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of the transmit frame |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a frame that is already offered but blocked. This happens when the previous frame has been fully read while its receive cause is still pending. To create it, the stimulus queues two frames back to back on the receive source. It drains the first frame with data reads and then lets cycles pass without acknowledging. The stimulus then shows three things: the second frame stays unaccepted, a write of 1 to the wrong cause bit does not release it, and the correct acknowledge loads the second frame's length.

// File: rtl/pktreg_pkg.sv
package pktreg_pkg;
  localparam logic [5:0] OFF_ID_LO  = 6'h00;
  localparam logic [5:0] OFF_ID_HI  = 6'h04;
  localparam logic [5:0] OFF_BUSY   = 6'h08;
  localparam logic [5:0] OFF_RX_CNT = 6'h0C;
  localparam logic [5:0] OFF_TX_CNT = 6'h10;
  localparam logic [5:0] OFF_CTRL   = 6'h14;
  localparam logic [5:0] OFF_INFO   = 6'h18;
  localparam logic [5:0] OFF_RX_DAT = 6'h1C;
  localparam logic [5:0] OFF_TX_DAT = 6'h20;

  localparam int BIT_TX_DONE = 0;
  localparam int BIT_RX_AVL  = 1;
  localparam int BIT_TEST    = 31;
endpackage

// File: rtl/pktreg_rx.sv
module pktreg_rx #(
  parameter int CNT_W = 17,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [LEN_W-1:0] rx_len_m1_i,
  input  logic             rd_data_i,
  input  logic             cause_i,
  output logic             start_o,
  output logic             pop_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign start_o = rx_valid_i && (cnt_q == '0) && !cause_i;
  assign pop_o   = rd_data_i && rx_valid_i && (cnt_q != '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_o) begin
      cnt_q <= CNT_W'(rx_len_m1_i) + CNT_W'(1);
    end else if (pop_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pktreg_tx.sv
module pktreg_tx #(
  parameter int MAX_BYTES = 65536,
  parameter int CNT_W     = 17,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cnt_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o
);
  localparam logic [DATA_W-1:0] MAX_W = DATA_W'(MAX_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             push;
  logic [CNT_W-1:0] load_val;

  assign push     = wr_data_i && (cnt_q != '0);
  assign done_o   = push && (cnt_q == CNT_W'(1));
  assign load_val = (wdata_i > MAX_W) ? CNT_W'(MAX_BYTES) : wdata_i[CNT_W-1:0];
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_last_o  <= 1'b0;
    end else begin
      tx_valid_o <= push;
      tx_last_o  <= done_o;
      if (push) begin
        tx_data_o <= wdata_i[7:0];
        cnt_q     <= cnt_q - CNT_W'(1);
      end else if (wr_cnt_i && (cnt_q == '0)) begin
        cnt_q <= load_val;
      end
    end
  end
endmodule

// File: rtl/pktreg_irq.sv
module pktreg_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_set_i,
  input  logic              rx_set_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              rx_cause_o,
  output logic              irq_o
);
  import pktreg_pkg::*;

  logic tx_q, rx_q, test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      test_q <= 1'b0;
    end else begin
      // device events win over a same-cycle acknowledge
      if (tx_set_i)                       tx_q <= 1'b1;
      else if (wr_i && wdata_i[BIT_TX_DONE]) tx_q <= 1'b0;
      if (rx_set_i)                       rx_q <= 1'b1;
      else if (wr_i && wdata_i[BIT_RX_AVL])  rx_q <= 1'b0;
      if (wr_i && wdata_i[BIT_TEST])      test_q <= 1'b1;
      else if (wr_i && (wdata_i == '0))   test_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o              = '0;
    ctrl_o[BIT_TX_DONE] = tx_q;
    ctrl_o[BIT_RX_AVL]  = rx_q;
    ctrl_o[BIT_TEST]    = test_q;
  end

  assign rx_cause_o = rx_q;
  assign irq_o      = tx_q | rx_q | test_q;
endmodule

// File: rtl/pktreg_top.sv
module pktreg_top #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 6,
  parameter int          MAX_BYTES = 65536,
  parameter logic [63:0] PROBE_ID  = "1EDONTKP",
  parameter logic [31:0] INFO_WORD = 32'h0000_0001,
  localparam int         CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int         LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i,
  input  logic [LEN_W-1:0]  rx_len_m1_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              irq_o
);
  import pktreg_pkg::*;

  logic [5:0]        word_addr;
  logic              rd, wr;
  logic              rd_rxdat, wr_txcnt, wr_txdat, wr_ctrl;
  logic [CNT_W-1:0]  rx_cnt, tx_cnt;
  logic              rx_start, rx_pop, rx_cause, tx_done;
  logic [DATA_W-1:0] ctrl;
  logic              busy;

  assign word_addr = {addr_i[5:2], 2'b00};
  assign rd        = req_i && !we_i;
  assign wr        = req_i && we_i;
  assign rd_rxdat  = rd && (word_addr == OFF_RX_DAT);
  assign wr_txcnt  = wr && (word_addr == OFF_TX_CNT);
  assign wr_txdat  = wr && (word_addr == OFF_TX_DAT);
  assign wr_ctrl   = wr && (word_addr == OFF_CTRL);
  assign busy      = (rx_cnt != '0) || (tx_cnt != '0);

  pktreg_rx #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_rx (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_len_m1_i,
    .rd_data_i (rd_rxdat),
    .cause_i   (rx_cause),
    .start_o   (rx_start),
    .pop_o     (rx_pop),
    .cnt_o     (rx_cnt)
  );

  pktreg_tx #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_cnt_i  (wr_txcnt),
    .wr_data_i (wr_txdat),
    .wdata_i,
    .cnt_o     (tx_cnt),
    .done_o    (tx_done),
    .tx_valid_o, .tx_data_o, .tx_last_o
  );

  pktreg_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i, .rst_ni,
    .wr_i       (wr_ctrl),
    .wdata_i,
    .tx_set_i   (tx_done),
    .rx_set_i   (rx_start),
    .ctrl_o     (ctrl),
    .rx_cause_o (rx_cause),
    .irq_o
  );

  assign rx_ready_o = rx_pop;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (word_addr)
        OFF_ID_LO:  rdata_o = PROBE_ID[31:0];
        OFF_ID_HI:  rdata_o = PROBE_ID[63:32];
        OFF_BUSY:   rdata_o = DATA_W'(busy);
        OFF_RX_CNT: rdata_o = DATA_W'(rx_cnt);
        OFF_TX_CNT: rdata_o = DATA_W'(tx_cnt);
        OFF_CTRL:   rdata_o = ctrl;
        OFF_INFO:   rdata_o = INFO_WORD;
        OFF_RX_DAT: rdata_o = rx_pop ? DATA_W'(rx_data_i) : '0;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pktreg_chk.sv
module pktreg_chk #(
  parameter int MAX_BYTES = 65536,
  parameter int CNT_W     = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [5:0]       addr_i,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [31:0]      ctrl
);
  logic tx_active;
  logic tx_wr;
  assign tx_active = (tx_cnt != '0);
  assign tx_wr     = req_i && we_i && (addr_i[5:2] == 4'h8) && tx_active;

  a_r4_pop_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |=> rx_cnt == $past(rx_cnt) - CNT_W'(1));

  a_r5_blocked_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == '0 && ctrl[1]) |=> rx_cnt == '0);

  a_r6_tx_cnt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CNT_W'(MAX_BYTES));

  a_r7_tx_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_wr));

  a_r8_done_sets_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_active) |-> ctrl[0]);
endmodule

bind pktreg_top pktreg_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rx_ready_o(rx_ready_o), .tx_valid_o(tx_valid_o),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .ctrl(ctrl)
);

// File: tb/test_pktreg_top.sv
`timescale 1ns/1ps
module test_pktreg_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rx_valid_i, rx_ready_o;
  logic [7:0]  rx_data_i;
  logic [15:0] rx_len_m1_i;
  logic        tx_valid_o, tx_last_o, irq_o;
  logic [7:0]  tx_data_o;

  int n_tests = 0, n_fail = 0;

  logic [7:0]  src_byte [16];
  logic [15:0] src_lm1  [16];
  int          src_n = 0, src_idx = 0;
  logic [7:0]  rx_exp [$];
  logic [8:0]  tx_exp [$];

  always #4 clk_i = ~clk_i;

  assign rx_valid_i  = src_idx < src_n;
  assign rx_data_i   = rx_valid_i ? src_byte[src_idx[3:0]] : 8'h00;
  assign rx_len_m1_i = rx_valid_i ? src_lm1[src_idx[3:0]] : 16'h0;

  pktreg_top i_pktreg_top (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d, output logic popped);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o; popped = rx_ready_o;
    @(negedge clk_i);
    req_i = 1'b0;
    if (popped) src_idx++;
  endtask

  task automatic add_frame(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      src_byte[src_n[3:0]] = base + 8'(i);
      src_lm1[src_n[3:0]]  = 16'(len - 1);
      rx_exp.push_back(base + 8'(i));
      src_n++;
    end
  endtask

  task automatic send_tx(logic [31:0] d, logic last);
    tx_exp.push_back({last, d[7:0]});
    bus_wr(6'h20, d);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // transmit monitor: pops the scoreboard as bytes appear
  always @(negedge clk_i) begin
    if (rst_ni && tx_valid_o) begin
      if (tx_exp.size() == 0) begin
        chk("R7 unexpected tx byte", {23'b0, tx_last_o, tx_data_o}, 32'h0);
      end else begin
        logic [8:0] e;
        e = tx_exp.pop_front();
        chk("R7 tx byte/last", {23'b0, tx_last_o, tx_data_o}, {23'b0, e});
      end
    end
  end

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        p;
    logic [63:0] id_exp;
    string       id_str;
    id_str = "PKTNODE1";
    for (int i = 0; i < 8; i++) id_exp[i*8 +: 8] = id_str[i];

    idle(2);
    rst_ni = 1'b1;
    idle(1);
    chk("reset irq", {31'b0, irq_o}, 0);
    chk("reset rx_ready", {31'b0, rx_ready_o}, 0);
    bus_rd(6'h08, d, p); chk("R2 reset busy", d, 0);
    bus_rd(6'h0C, d, p); chk("R3 reset rx count", d, 0);
    bus_rd(6'h10, d, p); chk("R6 reset tx count", d, 0);
    bus_rd(6'h14, d, p); chk("R9 reset ctrl", d, 0);

    bus_rd(6'h00, d, p); chk("R1 id low", d, id_exp[31:0]);
    bus_rd(6'h04, d, p); chk("R1 id high", d, id_exp[63:32]);
    bus_rd(6'h18, d, p); chk("R12 info", d, 32'h1);
    bus_rd(6'h20, d, p); chk("R12 tx data reads zero", d, 0);
    bus_rd(6'h3C, d, p); chk("R12 unmapped", d, 0);

    // two frames queued back to back
    add_frame(3, 8'h11);
    add_frame(2, 8'hA0);
    idle(3);
    bus_rd(6'h0C, d, p); chk("R3 rx count loaded", d, 3);
    bus_rd(6'h14, d, p); chk("R3 rx cause set", d, 32'h2);
    chk("R11 irq on rx", {31'b0, irq_o}, 1);
    bus_rd(6'h08, d, p); chk("R2 busy during rx", d, 1);
    for (int i = 0; i < 3; i++) begin
      bus_rd(6'h1C, d, p);
      chk("R4 rx byte", d, {24'b0, rx_exp.pop_front()});
      chk("R4 rx_ready pulse", {31'b0, p}, 1);
      bus_rd(6'h0C, d, p); chk("R4 count decrement", d, 32'(2 - i));
    end
    bus_rd(6'h1C, d, p); chk("R4 read at zero", d, 0);
    chk("R4 no pop at zero", {31'b0, p}, 0);
    bus_rd(6'h0C, d, p); chk("R4 count stays zero", d, 0);
    bus_rd(6'h08, d, p); chk("R2 idle busy", d, 0);

    idle(4);
    bus_rd(6'h0C, d, p); chk("R5 blocked frame not loaded", d, 0);
    bus_rd(6'h1C, d, p); chk("R5 no pop while blocked", {31'b0, p}, 0);
    bus_wr(6'h14, 32'h1);
    bus_rd(6'h14, d, p); chk("R9 other bit untouched", d, 32'h2);
    idle(2);
    bus_rd(6'h0C, d, p); chk("R5 still blocked", d, 0);
    bus_wr(6'h14, 32'h2);
    idle(2);
    bus_rd(6'h0C, d, p); chk("R3 second frame loaded", d, 2);
    bus_rd(6'h14, d, p); chk("R3 cause set again", d, 32'h2);
    for (int i = 0; i < 2; i++) begin
      bus_rd(6'h1C, d, p);
      chk("R4 second frame byte", d, {24'b0, rx_exp.pop_front()});
    end
    bus_wr(6'h14, 32'h2);
    bus_rd(6'h14, d, p); chk("R9 rx cause cleared", d, 0);
    chk("R11 irq low", {31'b0, irq_o}, 0);

    // transmit
    bus_wr(6'h10, 32'h3);
    bus_rd(6'h10, d, p); chk("R6 tx count loaded", d, 3);
    bus_rd(6'h08, d, p); chk("R2 busy during tx", d, 1);
    bus_wr(6'h10, 32'h9);
    bus_rd(6'h10, d, p); chk("R6 reload ignored", d, 3);
    send_tx(32'hFFFF_01C5, 1'b0);
    send_tx(32'h0000_0037, 1'b0);
    bus_rd(6'h14, d, p); chk("R8 no cause mid-frame", d, 0);
    send_tx(32'h1234_5699, 1'b1);
    idle(1);
    bus_rd(6'h10, d, p); chk("R8 tx count cleared", d, 0);
    bus_rd(6'h14, d, p); chk("R8 tx cause set", d, 32'h1);
    chk("R11 irq on tx", {31'b0, irq_o}, 1);
    bus_wr(6'h20, 32'h77);
    idle(2);
    chk("R7 write at zero ignored", 32'(tx_exp.size()), 0);
    bus_wr(6'h14, 32'h1);
    bus_rd(6'h14, d, p); chk("R9 tx cause cleared", d, 0);

    // test bit
    bus_wr(6'h14, 32'h8000_0000);
    bus_rd(6'h14, d, p); chk("R10 test bit set", d, 32'h8000_0000);
    chk("R11 irq on test", {31'b0, irq_o}, 1);
    bus_wr(6'h14, 32'hFFFF_FFFF);
    bus_rd(6'h14, d, p); chk("R10 only bit 31 readable", d, 32'h8000_0000);
    bus_wr(6'h14, 32'h0);
    bus_rd(6'h14, d, p); chk("R10 zero write clears", d, 0);
    chk("R11 irq cleared", {31'b0, irq_o}, 0);

    bus_wr(6'h10, 32'h0001_FFFF);
    bus_rd(6'h10, d, p); chk("R6 count capped", d, 32'h0001_0000);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule